// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block turns a decoded instruction into a CPU operand. The instruction supplies an addressing mode, a register value and a 32-bit displacement or immediate `disp`. The unit also receives the current program counter and stack pointer as inputs. From these it either returns the immediate itself or forms an effective address and reads the operand over a single-port data memory interface. Memory indirect mode chains two dependent reads. When the transfer ends, the unit returns the operand with a one-cycle `done` pulse.

The two auto-update modes also produce a register write-back value. This value is presented together with `done`. Auto-increment reads at the old register value and writes back the stepped value. Auto-decrement steps the register first and reads at the new value. Decoding, the ALU and memory writes are handled elsewhere.

Top module: `operand_fetch_unit`

## Requirements
- R1: Mode code 0 (immediate) returns `operand = disp` with `done`, and makes no memory read.
- R2: Mode 1 (direct) reads address `disp`. Mode 2 (register indirect) reads address `reg_val`. The operand is the data returned by the read.
- R3: Mode 3 (memory indirect) reads address `disp` first. It then reads at the data returned by that first read. The operand is the data of the second read.
- R4: Mode 4 (auto-increment) reads at `reg_val`. It raises `wb_en` with `wb_data = reg_val + n`, where `size_sel` 0,1,2,3 selects n = 1,2,4,8.
- R5: Mode 5 (auto-decrement) reads at `reg_val - n`, using the same `size_sel` encoding for n. It raises `wb_en` with `wb_data = reg_val - n`.
- R6: Mode 6 (indexed) reads at `reg_val + disp`. Mode 7 (scale-index-base) reads at `s*reg_val + disp`, where `size_sel` 0,1,2,3 selects s = 1,2,4,8.
- R7: Mode 8 reads at `pc_val + disp`. Mode 9 reads at `sp_val + disp`.
- R8: Mode codes 10 to 15 produce `done` with `illegal` high and `operand = 0`. They make no memory read and give no write-back.
- R9: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` holds its value. Reads happen one at a time.
- R10: A `start` that arrives while `busy` is high is ignored. The operation in flight completes unchanged, and no further operation follows it.
- R11: All address and write-back arithmetic wraps modulo 2^32.
- R12: After reset, `busy`, `done`, `mem_req` and `wb_en` are low.
- R13: `wb_en` is high only in the `done` cycle of modes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| mode | input | 4 | Addressing mode code |
| size_sel | input | 2 | Step or scale select: 1,2,4,8 |
| reg_val | input | 32 | Content of the named register |
| pc_val | input | 32 | Program counter value |
| sp_val | input | 32 | Stack pointer value |
| disp | input | 32 | Displacement or immediate |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 32 | Fetched operand, valid with done |
| illegal | output | 1 | Unused mode code, valid with done |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| wb_en | output | 1 | Register write-back strobe |
| wb_data | output | 32 | Updated register value |

## Verification
The bench sweeps all sixteen mode codes against every step/scale select. Each combination runs with three operand sets and with memory latencies of zero, one and two cycles. One operand set places the register just below 2^32 and the displacement near wrap, so that modulo arithmetic and the order of update versus access become visible. This separates increment from decrement and distinguishes the read-before-update and update-before-read orderings. The memory returns a data word that is a scrambled function of the address. Because of this, a wrong first address in memory indirect mode shows up in the second address. Every operation also receives a stray `start` while busy, which exposes any case where the unit re-arms mid-flight.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [3:0] {
        AM_IMM   = 4'd0,
        AM_DIR   = 4'd1,
        AM_RIND  = 4'd2,
        AM_MIND  = 4'd3,
        AM_AINC  = 4'd4,
        AM_ADEC  = 4'd5,
        AM_IDX   = 4'd6,
        AM_SIB   = 4'd7,
        AM_PCREL = 4'd8,
        AM_SPREL = 4'd9
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_DONE = 2'd3
    } fstate_e;

    typedef struct packed {
        logic illegal;
        logic use_mem;
        logic chain;
        logic upd;
    } plan_t;

    function automatic plan_t classify(input logic [3:0] m);
        plan_t p;
        p = '{illegal: 1'b0, use_mem: 1'b1, chain: 1'b0, upd: 1'b0};
        if (m > 4'd9) begin
            p.illegal = 1'b1;
            p.use_mem = 1'b0;
        end else begin
            case (amode_e'(m))
                AM_IMM:  p.use_mem = 1'b0;
                AM_MIND: p.chain   = 1'b1;
                AM_AINC: p.upd     = 1'b1;
                AM_ADEC: p.upd     = 1'b1;
                default: ;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
    import opf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size_sel,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] pc_val,
    input  logic [DW-1:0] sp_val,
    input  logic [DW-1:0] disp,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] upd_val
);
    logic [DW-1:0] step;
    logic [DW-1:0] scaled;

    assign step   = DW'(1) << size_sel;
    assign scaled = reg_val << size_sel;

    always_comb begin
        ea      = '0;
        upd_val = reg_val;
        if (mode <= 4'd9) begin
            case (amode_e'(mode))
                AM_DIR:   ea = disp;
                AM_RIND:  ea = reg_val;
                AM_MIND:  ea = disp;
                AM_AINC: begin
                    ea      = reg_val;
                    upd_val = reg_val + step;
                end
                AM_ADEC: begin
                    ea      = reg_val - step;
                    upd_val = reg_val - step;
                end
                AM_IDX:   ea = reg_val + disp;
                AM_SIB:   ea = scaled + disp;
                AM_PCREL: ea = pc_val + disp;
                AM_SPREL: ea = sp_val + disp;
                default:  ea = '0;
            endcase
        end
    end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
    import opf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  plan_t         plan,
    input  logic [DW-1:0] ea,
    input  logic [DW-1:0] upd_val,
    input  logic [DW-1:0] disp,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] operand,
    output logic          illegal,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    output logic          wb_en,
    output logic [DW-1:0] wb_data
);
    fstate_e       state;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] res_q;
    logic [DW-1:0] wbv_q;
    logic          chain_q;
    logic          upd_q;
    logic          ill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            res_q   <= '0;
            wbv_q   <= '0;
            chain_q <= 1'b0;
            upd_q   <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= ea;
                        wbv_q   <= upd_val;
                        chain_q <= plan.chain;
                        upd_q   <= plan.upd;
                        ill_q   <= plan.illegal;
                        if (plan.illegal) begin
                            res_q <= '0;
                            state <= ST_DONE;
                        end else if (!plan.use_mem) begin
                            res_q <= disp;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_RD1;
                        end
                    end
                end
                ST_RD1: begin
                    if (mem_rvalid) begin
                        if (chain_q) begin
                            addr_q <= mem_rdata;
                            state  <= ST_RD2;
                        end else begin
                            res_q <= mem_rdata;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_RD2: begin
                    if (mem_rvalid) begin
                        res_q <= mem_rdata;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign mem_req  = (state == ST_RD1) || (state == ST_RD2);
    assign mem_addr = addr_q;
    assign operand  = res_q;
    assign illegal  = done && ill_q;
    assign wb_en    = done && upd_q;
    assign wb_data  = wbv_q;
endmodule

// File: rtl/operand_fetch_unit.sv
module operand_fetch_unit
    import opf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [1:0]    size_sel,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] pc_val,
    input  logic [DW-1:0] sp_val,
    input  logic [DW-1:0] disp,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] operand,
    output logic          illegal,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic          wb_en,
    output logic [DW-1:0] wb_data
);
    plan_t         plan;
    logic [DW-1:0] ea;
    logic [DW-1:0] upd_val;

    assign plan = classify(mode);

    opf_ea_calc #(.DW(DW)) u_ea (
        .mode     (mode),
        .size_sel (size_sel),
        .reg_val  (reg_val),
        .pc_val   (pc_val),
        .sp_val   (sp_val),
        .disp     (disp),
        .ea       (ea),
        .upd_val  (upd_val)
    );

    opf_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plan       (plan),
        .ea         (ea),
        .upd_val    (upd_val),
        .disp       (disp),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .busy       (busy),
        .done       (done),
        .operand    (operand),
        .illegal    (illegal),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .wb_en      (wb_en),
        .wb_data    (wb_data)
    );
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          illegal,
    input logic          mem_req,
    input logic [DW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          wb_en
);
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !done && !wb_en));

    p_wb_in_done_r13: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (done && !mem_req));

    p_illegal_clean_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !wb_en));

    p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !mem_req);
endmodule

bind operand_fetch_unit opf_checker #(.DW(DW)) u_opf_checker (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .wb_en      (wb_en)
);

// File: tb/test_operand_fetch_unit.sv
module test_operand_fetch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size_sel = '0;
    logic [31:0] reg_val = '0, pc_val = '0, sp_val = '0, disp = '0;
    logic        busy, done, illegal, mem_req, wb_en;
    logic [31:0] operand, mem_addr, wb_data;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int cnt = 0;
    int rd_cnt = 0;
    logic [31:0] rd_addr [0:3];
    int cycles = 0;

    always #2 clk = ~clk;

    operand_fetch_unit i_operand_fetch_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .size_sel(size_sel),
        .reg_val(reg_val), .pc_val(pc_val), .sp_val(sp_val), .disp(disp),
        .busy(busy), .done(done), .operand(operand), .illegal(illegal),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .wb_en(wb_en), .wb_data(wb_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h3C5A_96E1;
    endfunction

    // memory model: answers after lat waiting cycles
    always @(negedge clk) begin
        cycles++;
        if (mem_req) begin
            if (cnt >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = memf(mem_addr);
                if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
                rd_cnt++;
                cnt = 0;
            end else begin
                mem_rvalid = 1'b0;
                mem_rdata  = 32'hDEAD_BEEF;
                cnt++;
            end
        end else begin
            mem_rvalid = 1'b0;
            cnt = 0;
        end
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (mode %0d sel %0d lat %0d)",
                     req, act, exp, mode, size_sel, lat);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [1:0] s,
                          input logic [31:0] r, input logic [31:0] d);
        logic [31:0] step, e_op, e_wb;
        logic [31:0] e_a [0:1];
        int          e_n;
        logic        e_ill, e_wb_en;
        string       req;
        int          guard;
        step = 32'd1 << s;
        e_n = 1; e_op = '0; e_wb = '0; e_ill = 1'b0; e_wb_en = 1'b0;
        e_a[0] = '0; e_a[1] = '0;
        case (m)
            4'd0: begin req = "R1";  e_n = 0; e_op = d; end
            4'd1: begin req = "R2";  e_a[0] = d; end
            4'd2: begin req = "R2";  e_a[0] = r; end
            4'd3: begin req = "R3";  e_n = 2; e_a[0] = d; e_a[1] = memf(d); end
            4'd4: begin req = "R4";  e_a[0] = r; e_wb_en = 1'b1; e_wb = r + step; end
            4'd5: begin req = "R5";  e_a[0] = r - step; e_wb_en = 1'b1; e_wb = r - step; end
            4'd6: begin req = "R6";  e_a[0] = r + d; end
            4'd7: begin req = "R6";  e_a[0] = r * step + d; end
            4'd8: begin req = "R7";  e_a[0] = pc_val + d; end
            4'd9: begin req = "R7";  e_a[0] = sp_val + d; end
            default: begin req = "R8"; e_n = 0; e_ill = 1'b1; end
        endcase
        if (e_n > 0) e_op = memf(e_a[e_n-1]);

        @(negedge clk);
        mode = m; size_sel = s; reg_val = r; disp = d; start = 1'b1;
        rd_cnt = 0;
        @(negedge clk);
        // stray start while busy (R10)
        check("R10 busy", {31'd0, busy}, 32'd1);
        mode = 4'd0; disp = 32'h5555_AAAA; reg_val = ~r;
        guard = 0;
        while (!done && guard < 50) begin
            @(negedge clk);
            start = 1'b0;
            guard++;
        end
        check({req, " done"}, {31'd0, done}, 32'd1);
        check({req, " operand"}, operand, e_op);
        check(e_ill ? "R8 illegal" : {req, " illegal"}, {31'd0, illegal}, {31'd0, e_ill});
        check(e_wb_en ? {req, " R13 wb_en"} : "R13 wb_en", {31'd0, wb_en}, {31'd0, e_wb_en});
        if (e_wb_en) check({req, " R11 wb_data"}, wb_data, e_wb);
        check({req, " read count"}, rd_cnt, e_n);
        for (int k = 0; k < e_n; k++) check({req, " R11 address"}, rd_addr[k], e_a[k]);
        @(negedge clk);
        start = 1'b0;
        check("R10 idle after", {30'd0, busy, mem_req}, 32'd0);
        @(negedge clk);
        check("R10 no rearm", {30'd0, busy, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 busy", {31'd0, busy}, 32'd0);
        check("R12 done", {31'd0, done}, 32'd0);
        check("R12 req", {31'd0, mem_req}, 32'd0);
        check("R12 wb_en", {31'd0, wb_en}, 32'd0);
        rst = 1'b0;
        for (int l = 0; l < 3; l++) begin
            lat = l;
            for (int v = 0; v < 3; v++) begin
                case (v)
                    0: begin pc_val = 32'h0000_1000; sp_val = 32'h0000_8000; end
                    1: begin pc_val = 32'hFFFF_FFF0; sp_val = 32'hFFFF_FF00; end
                    default: begin pc_val = 32'h8000_0004; sp_val = 32'h7FFF_FFFC; end
                endcase
                for (int m = 0; m < 16; m++) begin
                    for (int s = 0; s < 4; s++) begin
                        case (v)
                            0: run_op(4'(m), 2'(s), 32'h0000_0200, 32'h0000_0020);
                            1: run_op(4'(m), 2'(s), 32'hFFFF_FFFC, 32'h0000_0010);
                            default: run_op(4'(m), 2'(s), 32'h0000_0002, 32'hFFFF_FFF8);
                        endcase
                    end
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule